// File: doc/BRIEF.md
# Bit-plane LED matrix scan controller

This block refreshes a 16 x 16 LED matrix with three grayscale bit planes by lighting one row at a time. For each (plane, row) pair it reads the column bytes from a synchronous frame-buffer read port during a blanking gap. It then steps the row lines and shows the columns for a dwell time that depends on the plane. Row lines come from two external 8-bit serial-in shift registers. The registers share a clock and an active-low clear, and each has its own data input. The block walks a single active bit through them: it loads the bit into the first register at row 0, clears both and loads the second register at row 8, and otherwise gives one clock pulse per row.

Dwell times are counted in ticks of a system-clock prescaler. The scan runs through all rows of plane 0, then all rows of plane 1, then plane 2, and starts again. A one-cycle heartbeat marks every completed row sweep, so an external watchdog can tell that refresh is alive. When the enable input is low, every output is held at zero, and the next enable restarts the scan at plane 0, row 0.

Top module: `ledscan_top`

## Requirements
- R1: One clock after reset, or after a clock edge that samples `en` low, `col_out`, `sr_clk`, `sr_clr_n`, `sr_din` and `frame_beat` are all zero.
- R2: Frame-buffer address bits [6:5] give the plane, bits [4:1] the row and bit [0] the byte. The read has one cycle of latency. `col_out[7:0]` shows byte 0 and `col_out[15:8]` shows byte 1 of the current plane and row.
- R3: The columns of a row stay lit for (C+1)*PRESCALE clock cycles. C is 2 for plane 0, 5 for plane 1 and 22 for plane 2.
- R4: The first row shown after enable uses C = 20, whatever its plane.
- R5: Rows advance 0 to 15 inside a plane. After row 15 the row returns to 0 and the plane advances 0, 1, 2, then back to 0. The scan starts at plane 0, row 0.
- R6: Between two lit rows, the columns are zero for DEAD_CYC cycles (10) plus the row-line sequence: 5 cycles, or 7 cycles when the new row is 8. No row-line clock or clear edge occurs earlier than DEAD_CYC cycles after the columns go to zero.
- R7: For row 0, `sr_din[0]` is raised, one `sr_clk` pulse is given and the data is lowered. While row 0 is lit, only bit 0 of the first register is set.
- R8: For row 8, `sr_clr_n` is held low for 2 cycles, then `sr_din[1]` is loaded with one pulse. While row 8 is lit, only bit 0 of the second register is set.
- R9: Every other row is reached by a single `sr_clk` pulse with both data inputs low. While a row r is lit, exactly one of the 16 row lines is active: line r (register 0 bit r for r<8, register 1 bit r-8).
- R10: Each `sr_clk` pulse is high for exactly 2 cycles and then low for at least 2 cycles. `sr_din` is set one cycle before the rising edge and does not change at it. At most one data input is high at a time.
- R11: `frame_beat` is high for one cycle: the first zero-column cycle after row 15 of any plane has been shown. It is never high at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Scan enable; low blanks all outputs and restarts the scan |
| fb_addr | output | 7 | Frame-buffer read address {plane, row, byte} |
| fb_rdata | input | 8 | Frame-buffer read data, one cycle after the address |
| col_out | output | 16 | Column drive, high = on |
| sr_clk | output | 1 | Shared shift-register clock |
| sr_clr_n | output | 1 | Shared active-low shift-register clear |
| sr_din | output | 2 | Serial data input for each shift register |
| frame_beat | output | 1 | One-cycle pulse per completed row sweep |

## Verification
The columns of a row light up DEAD_CYC plus 5 (or 7 at row 8) cycles after the previous row went dark. They stay lit for exactly (C+1)*PRESCALE cycles. The outputs drop one edge after `en` is sampled low, and the heartbeat lands in the same cycle that row 15's columns go dark. A driver task queues each expected row with its column value, lit length, dark gap and active row line. A monitor samples at the falling clock edge. It measures lit and dark run lengths in whole cycles, replays the row-line pins into a model of the two shift registers, and compares each finished run against the head of the queue. Timing mismatches therefore show up as length errors rather than through sampling at guessed cycles.

// File: rtl/ledscan_pkg.sv
package ledscan_pkg;

  typedef enum logic [1:0] {
    SQ_OFF,
    SQ_BLANK,
    SQ_ROWSEL,
    SQ_SHOW
  } seq_state_e;

  typedef enum logic [2:0] {
    RD_IDLE,
    RD_CLR,
    RD_SETUP,
    RD_HIGH,
    RD_LOW
  } rd_state_e;

  function automatic int clog2_min1(input int v);
    return (v <= 2) ? 1 : $clog2(v);
  endfunction

endpackage

// File: rtl/ledscan_tick.sv
module ledscan_tick #(
  parameter int PRESCALE = 256
) (
  input  logic clk,
  input  logic clr,
  input  logic restart,
  output logic tick
);
  localparam int PCW = ledscan_pkg::clog2_min1(PRESCALE);
  localparam logic [PCW-1:0] P_LAST = PCW'(PRESCALE - 1);

  logic [PCW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr || restart || cnt == P_LAST) cnt <= '0;
    else                                 cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == P_LAST);
endmodule

// File: rtl/ledscan_rowdrv.sv
module ledscan_rowdrv
  import ledscan_pkg::*;
#(
  parameter int NUM_ROWS  = 16,
  parameter int SR_BITS   = 8,
  parameter int PULSE_CYC = 2,
  localparam int RW     = clog2_min1(NUM_ROWS),
  localparam int NUM_SR = NUM_ROWS / SR_BITS
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              start,
  input  logic [RW-1:0]     row,
  output logic              sr_clk,
  output logic              sr_clr_n,
  output logic [NUM_SR-1:0] sr_din,
  output logic              done
);
  localparam int SBW = clog2_min1(SR_BITS);
  localparam int WW  = clog2_min1(NUM_SR);
  localparam int PCW = clog2_min1(PULSE_CYC);
  localparam logic [PCW-1:0] C_LAST = PCW'(PULSE_CYC - 1);

  rd_state_e      st, nxt;
  logic [PCW-1:0] cnt, ncnt;
  logic           load_q, load_n;
  logic [WW-1:0]  which_q, which_n;
  logic           load_now, wipe_now;
  logic [WW-1:0]  which_now;

  // a register boundary loads a fresh bit; every boundary but the first also clears
  assign load_now  = (row[SBW-1:0] == '0);
  assign wipe_now  = load_now && (row != '0);
  assign which_now = WW'(row >> SBW);

  always_comb begin
    nxt     = st;
    ncnt    = cnt;
    load_n  = load_q;
    which_n = which_q;
    unique case (st)
      RD_IDLE: if (start) begin
        nxt     = wipe_now ? RD_CLR : RD_SETUP;
        ncnt    = '0;
        load_n  = load_now;
        which_n = which_now;
      end
      RD_CLR: begin
        if (cnt == C_LAST) begin nxt = RD_SETUP; ncnt = '0; end
        else ncnt = cnt + 1'b1;
      end
      RD_SETUP: begin nxt = RD_HIGH; ncnt = '0; end
      RD_HIGH: begin
        if (cnt == C_LAST) begin nxt = RD_LOW; ncnt = '0; end
        else ncnt = cnt + 1'b1;
      end
      RD_LOW: begin
        if (cnt == C_LAST) begin nxt = RD_IDLE; ncnt = '0; end
        else ncnt = cnt + 1'b1;
      end
      default: nxt = RD_IDLE;
    endcase
  end

  assign done = (st == RD_LOW) && (cnt == C_LAST);

  always_ff @(posedge clk) begin
    if (clr) begin
      st       <= RD_IDLE;
      cnt      <= '0;
      load_q   <= 1'b0;
      which_q  <= '0;
      sr_clk   <= 1'b0;
      sr_clr_n <= 1'b0;
      sr_din   <= '0;
    end else begin
      st       <= nxt;
      cnt      <= ncnt;
      load_q   <= load_n;
      which_q  <= which_n;
      sr_clk   <= (nxt == RD_HIGH);
      sr_clr_n <= (nxt != RD_CLR);
      sr_din   <= (load_n && (nxt == RD_SETUP || nxt == RD_HIGH))
                  ? (NUM_SR'(1) << which_n) : '0;
    end
  end
endmodule

// File: rtl/ledscan_seq.sv
module ledscan_seq
  import ledscan_pkg::*;
#(
  parameter int NUM_ROWS   = 16,
  parameter int NUM_COLS   = 16,
  parameter int NUM_PLANES = 3,
  parameter int CMP_W      = 8,
  parameter logic [NUM_PLANES*CMP_W-1:0] DWELL_CMP = {8'd22, 8'd5, 8'd2},
  parameter int FIRST_CMP  = 20,
  parameter int DEAD_CYC   = 10,
  localparam int RW = clog2_min1(NUM_ROWS),
  localparam int PW = clog2_min1(NUM_PLANES),
  localparam int COL_BYTES = NUM_COLS / 8,
  localparam int BW = clog2_min1(COL_BYTES),
  localparam int AW = PW + RW + BW
) (
  input  logic                clk,
  input  logic                clr,
  input  logic                tick,
  input  logic                rd_done,
  input  logic [7:0]          fb_rdata,
  output logic                rd_start,
  output logic [RW-1:0]       rd_row,
  output logic                prescale_restart,
  output logic [AW-1:0]       fb_addr,
  output logic [NUM_COLS-1:0] col_out,
  output logic                frame_beat
);
  localparam int DW = clog2_min1(DEAD_CYC);
  localparam logic [DW-1:0]    DC_LAST  = DW'(DEAD_CYC - 1);
  localparam logic [RW-1:0]    ROW_LAST = RW'(NUM_ROWS - 1);
  localparam logic [PW-1:0]    PL_LAST  = PW'(NUM_PLANES - 1);
  localparam logic [CMP_W-1:0] FIRST_V  = CMP_W'(FIRST_CMP);

  seq_state_e          state;
  logic [RW-1:0]       row;
  logic [PW-1:0]       plane;
  logic [DW-1:0]       dc;
  logic [CMP_W-1:0]    tcnt, cmp;
  logic                first;
  logic [NUM_COLS-1:0] colbuf;

  always_comb begin
    cmp = DWELL_CMP[CMP_W-1:0];
    for (int i = 0; i < NUM_PLANES; i++)
      if (plane == PW'(i)) cmp = DWELL_CMP[i*CMP_W +: CMP_W];
    if (first) cmp = FIRST_V;
  end

  assign rd_start         = (state == SQ_BLANK) && (dc == DC_LAST);
  assign rd_row           = row;
  assign prescale_restart = (state == SQ_ROWSEL) && rd_done;
  assign fb_addr          = {plane, row, dc[BW-1:0]};

  always_ff @(posedge clk) begin
    if (clr) begin
      state      <= SQ_OFF;
      row        <= '0;
      plane      <= '0;
      dc         <= '0;
      tcnt       <= '0;
      first      <= 1'b1;
      colbuf     <= '0;
      col_out    <= '0;
      frame_beat <= 1'b0;
    end else begin
      frame_beat <= 1'b0;
      unique case (state)
        SQ_OFF: begin
          state <= SQ_BLANK;
          dc    <= '0;
        end
        SQ_BLANK: begin
          // address for byte b is out at dc=b, its data returns at dc=b+1
          for (int b = 0; b < COL_BYTES; b++)
            if (dc == DW'(b + 1)) colbuf[b*8 +: 8] <= fb_rdata;
          if (dc == DC_LAST) state <= SQ_ROWSEL;
          else               dc    <= dc + 1'b1;
        end
        SQ_ROWSEL: if (rd_done) begin
          state   <= SQ_SHOW;
          col_out <= colbuf;
          tcnt    <= '0;
        end
        SQ_SHOW: if (tick) begin
          if (tcnt == cmp) begin
            state   <= SQ_BLANK;
            dc      <= '0;
            col_out <= '0;
            first   <= 1'b0;
            if (row == ROW_LAST) begin
              row        <= '0;
              frame_beat <= 1'b1;
              plane      <= (plane == PL_LAST) ? '0 : plane + 1'b1;
            end else begin
              row <= row + 1'b1;
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: state <= SQ_OFF;
      endcase
    end
  end
endmodule

// File: rtl/ledscan_top.sv
module ledscan_top
  import ledscan_pkg::*;
#(
  parameter int NUM_ROWS   = 16,
  parameter int NUM_COLS   = 16,
  parameter int SR_BITS    = 8,
  parameter int NUM_PLANES = 3,
  parameter int CMP_W      = 8,
  parameter logic [NUM_PLANES*CMP_W-1:0] DWELL_CMP = {8'd22, 8'd5, 8'd2},
  parameter int FIRST_CMP  = 20,
  parameter int PRESCALE   = 256,
  parameter int DEAD_CYC   = 10,
  parameter int PULSE_CYC  = 2,
  localparam int RW     = clog2_min1(NUM_ROWS),
  localparam int PW     = clog2_min1(NUM_PLANES),
  localparam int BW     = clog2_min1(NUM_COLS / 8),
  localparam int AW     = PW + RW + BW,
  localparam int NUM_SR = NUM_ROWS / SR_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  output logic [AW-1:0]       fb_addr,
  input  logic [7:0]          fb_rdata,
  output logic [NUM_COLS-1:0] col_out,
  output logic                sr_clk,
  output logic                sr_clr_n,
  output logic [NUM_SR-1:0]   sr_din,
  output logic                frame_beat
);
  logic          clr;
  logic          tick, restart, rd_start, rd_done;
  logic [RW-1:0] rd_row;

  assign clr = rst || !en;

  ledscan_tick #(.PRESCALE(PRESCALE)) i_tick (
    .clk(clk), .clr(clr), .restart(restart), .tick(tick)
  );

  ledscan_seq #(
    .NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS), .NUM_PLANES(NUM_PLANES),
    .CMP_W(CMP_W), .DWELL_CMP(DWELL_CMP), .FIRST_CMP(FIRST_CMP),
    .DEAD_CYC(DEAD_CYC)
  ) i_seq (
    .clk(clk), .clr(clr), .tick(tick), .rd_done(rd_done),
    .fb_rdata(fb_rdata), .rd_start(rd_start), .rd_row(rd_row),
    .prescale_restart(restart), .fb_addr(fb_addr), .col_out(col_out),
    .frame_beat(frame_beat)
  );

  ledscan_rowdrv #(
    .NUM_ROWS(NUM_ROWS), .SR_BITS(SR_BITS), .PULSE_CYC(PULSE_CYC)
  ) i_rowdrv (
    .clk(clk), .clr(clr), .start(rd_start), .row(rd_row),
    .sr_clk(sr_clk), .sr_clr_n(sr_clr_n), .sr_din(sr_din), .done(rd_done)
  );
endmodule

// File: rtl/ledscan_chk.sv
module ledscan_chk #(
  parameter int NUM_COLS = 16,
  parameter int NUM_SR   = 2,
  parameter int DEAD_CYC = 10
) (
  input logic                clk,
  input logic                rst,
  input logic                en,
  input logic [NUM_COLS-1:0] col_out,
  input logic                sr_clk,
  input logic                sr_clr_n,
  input logic [NUM_SR-1:0]   sr_din,
  input logic                frame_beat
);
  int dark_cnt;

  always_ff @(posedge clk) begin
    if (rst || col_out != '0) dark_cnt <= 0;
    else if (dark_cnt < DEAD_CYC) dark_cnt <= dark_cnt + 1;
  end

  assert_blank_on_disable_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> (col_out == '0 && !sr_clk && !sr_clr_n && sr_din == '0 && !frame_beat));

  assert_dark_before_clock_R6: assert property (@(posedge clk) disable iff (rst || !en)
    $rose(sr_clk) |-> dark_cnt >= DEAD_CYC);

  assert_dark_before_clear_R6: assert property (@(posedge clk) disable iff (rst || !en)
    $fell(sr_clr_n) |-> dark_cnt >= DEAD_CYC);

  assert_rows_quiet_when_lit_R6: assert property (@(posedge clk) disable iff (rst)
    (col_out != '0) |-> (!sr_clk && sr_clr_n));

  assert_clock_high_width_R10: assert property (@(posedge clk) disable iff (rst || !en)
    $rose(sr_clk) |=> sr_clk);

  assert_clock_low_width_R10: assert property (@(posedge clk) disable iff (rst || !en)
    $fell(sr_clk) |=> !sr_clk);

  assert_data_setup_R10: assert property (@(posedge clk) disable iff (rst || !en)
    $rose(sr_clk) |-> $stable(sr_din));

  assert_data_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sr_din));

  assert_beat_single_R11: assert property (@(posedge clk) disable iff (rst)
    frame_beat |=> !frame_beat);

  assert_beat_when_dark_R11: assert property (@(posedge clk) disable iff (rst)
    frame_beat |-> col_out == '0);
endmodule

bind ledscan_top ledscan_chk #(
  .NUM_COLS(NUM_COLS), .NUM_SR(NUM_SR), .DEAD_CYC(DEAD_CYC)
) i_chk (
  .clk(clk), .rst(rst), .en(en), .col_out(col_out), .sr_clk(sr_clk),
  .sr_clr_n(sr_clr_n), .sr_din(sr_din), .frame_beat(frame_beat)
);

// File: tb/test_ledscan_top.sv
module test_ledscan_top;
  localparam int CLK_PERIOD = 10;
  localparam int PRE   = 4;
  localparam int DEAD  = 10;
  localparam int PULSE = 2;
  localparam int FIRST = 20;
  localparam int WDOG  = 100000;

  typedef struct {
    logic [15:0] val;
    int          len;
    int          gap;
    int          row;
    bit          first;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [6:0]  fb_addr;
  logic [7:0]  fb_rdata = 8'h00;
  logic [15:0] col_out;
  logic        sr_clk, sr_clr_n, frame_beat;
  logic [1:0]  sr_din;

  logic [7:0] mem [128];
  item_t      exp_q [$];
  int         total = 0, bad = 0;
  int         g_p = 0, g_r = 0;
  bit         g_first = 1'b1;
  bit         mon_on = 1'b0;
  bit         done_flag = 1'b0;

  ledscan_top #(.PRESCALE(PRE), .DEAD_CYC(DEAD), .PULSE_CYC(PULSE), .FIRST_CMP(FIRST)) i_ledscan_top (
    .clk(clk), .rst(rst), .en(en), .fb_addr(fb_addr), .fb_rdata(fb_rdata),
    .col_out(col_out), .sr_clk(sr_clk), .sr_clr_n(sr_clr_n), .sr_din(sr_din),
    .frame_beat(frame_beat)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) fb_rdata <= mem[fb_addr];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic int dwell_cmp(input int p);
    case (p)
      0: return 2;
      1: return 5;
      default: return 22;
    endcase
  endfunction

  // driver: queue the next n rows of the scan (R2 R3 R4 R5 R6)
  task automatic push_items(input int n);
    for (int k = 0; k < n; k++) begin
      item_t it;
      int c;
      c        = g_first ? FIRST : dwell_cmp(g_p);
      it.val   = {mem[g_p*32 + g_r*2 + 1], mem[g_p*32 + g_r*2]};
      it.len   = (c + 1) * PRE;
      it.gap   = DEAD + 1 + 2*PULSE + ((g_r == 8) ? PULSE : 0);
      it.row   = g_r;
      it.first = g_first;
      exp_q.push_back(it);
      g_first = 1'b0;
      if (g_r == 15) begin
        g_r = 0;
        g_p = (g_p == 2) ? 0 : g_p + 1;
      end else begin
        g_r++;
      end
    end
  endtask

  // shift-register model and monitor
  logic [7:0] m0 = 8'h00, m1 = 8'h00;
  logic       prev_clk = 1'b0;
  int         hi_len = 0, run_len = 0, dark = 0;
  bit         in_run = 1'b0;
  item_t      cur;

  always @(negedge clk) begin
    if (sr_clr_n === 1'b0) begin
      m0 = 8'h00; m1 = 8'h00;
    end else if (sr_clk === 1'b1 && prev_clk === 1'b0) begin
      m0 = {m0[6:0], sr_din[0]};
      m1 = {m1[6:0], sr_din[1]};
    end
    if (!mon_on) begin
      in_run = 1'b0; hi_len = 0; run_len = 0; dark = 0;
    end else begin
      if (sr_clk === 1'b1) hi_len++;
      else if (prev_clk === 1'b1) begin
        check(hi_len == PULSE, "R10", "row clock high width", hi_len, PULSE);
        hi_len = 0;
      end
      if (col_out != 16'h0) begin
        if (!in_run) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R5", "unexpected lit row", col_out, 0);
          end else begin
            string rq;
            cur = exp_q[0];
            rq = (cur.row == 0) ? "R7" : (cur.row == 8) ? "R8" : "R9";
            check({m1, m0} == (16'h1 << cur.row), rq, "active row line",
                  {m1, m0}, 16'h1 << cur.row);
            if (!cur.first)
              check(dark == cur.gap, "R6", "dark gap cycles", dark, cur.gap);
          end
          in_run = 1'b1;
          run_len = 0;
        end
        run_len++;
        if (frame_beat) check(1'b0, "R11", "beat while lit", 1, 0);
      end else begin
        if (in_run && exp_q.size() != 0) begin
          cur = exp_q.pop_front();
          check(col_out_last == cur.val, "R2,R5", "column value", col_out_last, cur.val);
          check(run_len == cur.len, cur.first ? "R4" : "R3", "lit cycles", run_len, cur.len);
          check(frame_beat == (cur.row == 15), "R11", "beat at row end", frame_beat, cur.row == 15);
          dark = 1;
        end else begin
          if (frame_beat) check(1'b0, "R11", "stray beat", 1, 0);
          dark++;
        end
        in_run = 1'b0;
      end
    end
    prev_clk = sr_clk;
    col_out_last = col_out;
  end
  logic [15:0] col_out_last = 16'h0;

  task automatic check_all_zero(input string what);
    check(col_out == 16'h0 && sr_clk == 1'b0 && sr_clr_n == 1'b0 &&
          sr_din == 2'b00 && frame_beat == 1'b0, "R1", what,
          {col_out, sr_clk, sr_clr_n, sr_din, frame_beat}, 0);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 8'(i*53 + 17) | 8'h01;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all_zero("outputs in reset");
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check_all_zero("outputs with enable low");

    push_items(97);
    mon_on = 1'b1;
    en = 1'b1;
    drain();
    mon_on = 1'b0;
    repeat (40) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check_all_zero("outputs one cycle after disable");
    repeat (6) @(negedge clk);
    check_all_zero("outputs while disabled");

    g_p = 0; g_r = 0; g_first = 1'b1;
    push_items(20);
    mon_on = 1'b1;
    en = 1'b1;
    drain();
    mon_on = 1'b0;
    repeat (5) @(negedge clk);
    done_flag = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done_flag) begin
      total++;
      bad++;
      $display("FAIL R5 watchdog expired: actual=%0d expected=%0d", exp_q.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule